// File: doc/BRIEF.md
# Sampling Converter Serial Result Port

This block is the digital output side of a sampling converter, built as synthesizable logic. When the read/convert input and the select input are low together while the unit is idle, conversion n begins. Busy drops, and a cycle-count timer stands in for the analog conversion. In parallel, a self-timed burst of exactly sixteen data-clock pulses carries the result of conversion n-1 out on a single serial line, most significant bit first.

When the conversion timer expires, busy rises and the parallel result input is captured. That captured word is what the next conversion will send. Once the burst is over, the serial line drives the level seen on the tag input during the first data-clock pulse. Several converters can therefore be chained, each one's serial line feeding the next one's tag input.

The data-clock rate is set by a quarter-period parameter counted in system clocks. The conversion length is a separate cycle-count parameter. An elaboration check requires the conversion to outlast the burst.

Top module: `conv_serial_out`

## Requirements
- R1: A conversion starts only on a clock edge at which `rdconv_n` and `select_n` are both 0 and `busy` is 1. `busy` is 0 from the next cycle on. With only one of the two inputs low, nothing starts.
- R2: Each conversion gives exactly DATA_W (16) data-clock pulses. Counting cycles from the one after the start edge, bit slot k spans cycles 4·QTR·k to 4·QTR·(k+1)-1. Within a slot, `dclk` is 1 at offsets QTR to 3·QTR-1 and 0 at all other offsets.
- R3: During slot k, `sdata` carries bit DATA_W-1-k of the previous conversion's result, so the MSB is sent first.
- R4: `sdata` changes only at slot boundaries, QTR cycles away from either data-clock edge. It never changes in a cycle where `dclk` changes.
- R5: After the last pulse, `dclk` stays 0 until the next conversion starts. It is always 0 while `busy` is 1.
- R6: Once the burst is over, `sdata` drives the value that `tag_in` had in the cycle at offset QTR of slot 0, which is the first high cycle of the data clock. It holds that value until the next start.
- R7: `busy` stays 0 for exactly CONV_CYCLES cycles and then rises. The word on `result_in` in the last low cycle is stored, and the next conversion sends it.
- R8: A start request while `busy` is 0 is ignored. The conversion length, the burst and the stored result are unchanged.
- R9: After reset, `busy` is 1, `dclk` is 0, the stored result and the tag level are 0, and `sdata` drives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdconv_n | input | 1 | Read/convert control; low together with `select_n` requests a conversion |
| select_n | input | 1 | Active-low select |
| tag_in | input | 1 | Serial level forwarded after the burst (daisy chain input) |
| result_in | input | DATA_W | New conversion result, captured when the timer expires |
| busy | output | 1 | Low while a conversion runs; rising edge marks data ready |
| dclk | output | 1 | Self-generated data clock, 16 pulses per conversion |
| sdata | output | 1 | Serial data, always driven |

## Verification
The bench sends words with set bits at both ends, alternating patterns and near-full values, so that a reversed bit order or an off-by-one shift shows up as a swapped or doubled bit. It changes `tag_in` just after the first pulse, which catches a design that samples the tag late or tracks it live: such a design would forward the new level instead of the captured one. It raises start requests with only one control low and also during a running conversion. A design that decodes the start loosely or restarts while busy would then shorten the busy window or send the burst twice. It also starts a conversion on the cycle right after busy rises, to show that the word just captured is the one sent next.

// File: rtl/conv_serial_pkg.sv
package conv_serial_pkg;

   // Number of system-clock cycles in one serial bit slot.
   function automatic int slot_cycles(input int qtr);
      return 4 * qtr;
   endfunction

   // Total burst length in system-clock cycles.
   function automatic int burst_cycles(input int qtr, input int nbits);
      return 4 * qtr * nbits;
   endfunction

   // Phase of the data clock inside a bit slot.
   typedef enum logic [1:0] {
      PH_LEAD  = 2'd0,   // data settled, clock low
      PH_HIGH  = 2'd1,   // clock high
      PH_TRAIL = 2'd2    // clock low again, data held
   } slot_phase_e;

endpackage

// File: rtl/conv_start_timer.sv
module conv_start_timer #(
   parameter int CONV_CYCLES = 2375
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdconv_n,
   input  logic select_n,
   output logic busy,
   output logic start,
   output logic load
);
   localparam int CW = $clog2(CONV_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   assign start = busy_q & ~rdconv_n & ~select_n;
   assign load  = ~busy_q & (cnt_q == LAST);
   assign busy  = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/conv_burst_gen.sv
module conv_burst_gen
   import conv_serial_pkg::*;
#(
   parameter int QTR    = 35,
   parameter int NBITS  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic dclk,
   output logic shift_adv,
   output logic tag_strobe
);
   localparam int SLOT = slot_cycles(QTR);
   localparam int PW   = $clog2(SLOT);
   localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1;
   localparam logic [PW-1:0] P_RISE = PW'(QTR);
   localparam logic [PW-1:0] P_FALL = PW'(3 * QTR);
   localparam logic [PW-1:0] P_END  = PW'(SLOT - 1);
   localparam logic [BW-1:0] B_LAST = BW'(NBITS - 1);

   logic          act_q, act_d;
   logic [PW-1:0] ph_q, ph_d;
   logic [BW-1:0] bi_q, bi_d;
   logic          dclk_q, dclk_d;
   logic          adv;
   slot_phase_e   ph_class;

   always_comb begin
      act_d = act_q;
      ph_d  = ph_q;
      bi_d  = bi_q;
      adv   = 1'b0;
      if (start) begin
         act_d = 1'b1;
         ph_d  = '0;
         bi_d  = '0;
      end else if (act_q) begin
         if (ph_q == P_END) begin
            adv  = 1'b1;
            ph_d = '0;
            if (bi_q == B_LAST) act_d = 1'b0;
            else                bi_d  = bi_q + BW'(1);
         end else begin
            ph_d = ph_q + PW'(1);
         end
      end
   end

   always_comb begin
      if (ph_d < P_RISE)      ph_class = PH_LEAD;
      else if (ph_d < P_FALL) ph_class = PH_HIGH;
      else                    ph_class = PH_TRAIL;
      dclk_d = act_d && (ph_class == PH_HIGH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         ph_q   <= '0;
         bi_q   <= '0;
         dclk_q <= 1'b0;
      end else begin
         act_q  <= act_d;
         ph_q   <= ph_d;
         bi_q   <= bi_d;
         dclk_q <= dclk_d;
      end
   end

   assign active     = act_q;
   assign dclk       = dclk_q;
   assign shift_adv  = adv;
   assign tag_strobe = act_q && (bi_q == '0) && (ph_q == P_RISE);
endmodule

// File: rtl/conv_result_shifter.sv
module conv_result_shifter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              load,
   input  logic              shift_adv,
   input  logic              tag_strobe,
   input  logic              active,
   input  logic [DATA_W-1:0] result_in,
   input  logic              tag_in,
   output logic              sdata
);
   logic [DATA_W-1:0] prev_q;
   logic [DATA_W-1:0] sh_q;
   logic              tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         sh_q   <= '0;
         tag_q  <= 1'b0;
      end else begin
         if (load)       prev_q <= result_in;
         if (start)      sh_q   <= prev_q;
         else if (shift_adv) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
         if (tag_strobe) tag_q  <= tag_in;
      end
   end

   assign sdata = active ? sh_q[DATA_W-1] : tag_q;
endmodule

// File: rtl/conv_serial_out.sv
module conv_serial_out #(
   parameter int DATA_W      = 16,
   parameter int QTR         = 35,    // 4*35 cycles at 125 MHz: about 893 kHz data clock
   parameter int CONV_CYCLES = 2375   // 19 us at 125 MHz
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rdconv_n,
   input  logic              select_n,
   input  logic              tag_in,
   input  logic [DATA_W-1:0] result_in,
   output logic              busy,
   output logic              dclk,
   output logic              sdata
);
   localparam int BURST = conv_serial_pkg::burst_cycles(QTR, DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("conv_serial_out: DATA_W must be at least 2");
      end
      if (QTR < 1) begin : g_bad_qtr
         $error("conv_serial_out: QTR must be at least 1");
      end
      if (CONV_CYCLES <= BURST) begin : g_bad_conv
         $error("conv_serial_out: CONV_CYCLES must exceed the burst length");
      end
   endgenerate

   logic start, load, active, shift_adv, tag_strobe;

   conv_start_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdconv_n (rdconv_n),
      .select_n (select_n),
      .busy     (busy),
      .start    (start),
      .load     (load)
   );

   conv_burst_gen #(.QTR(QTR), .NBITS(DATA_W)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .active     (active),
      .dclk       (dclk),
      .shift_adv  (shift_adv),
      .tag_strobe (tag_strobe)
   );

   conv_result_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .load       (load),
      .shift_adv  (shift_adv),
      .tag_strobe (tag_strobe),
      .active     (active),
      .result_in  (result_in),
      .tag_in     (tag_in),
      .sdata      (sdata)
   );
endmodule

// File: rtl/conv_serial_out_chk.sv
module conv_serial_out_chk #(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 2375
) (
   input logic clk,
   input logic rst_n,
   input logic rdconv_n,
   input logic select_n,
   input logic busy,
   input logic dclk,
   input logic sdata
);
   int   lowcnt;
   int   pulses;
   logic dclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowcnt    <= 0;
         pulses    <= 0;
         dclk_prev <= 1'b0;
      end else begin
         lowcnt    <= busy ? 0 : lowcnt + 1;
         pulses    <= busy ? 0 : pulses + ((dclk && !dclk_prev) ? 1 : 0);
         dclk_prev <= dclk;
      end
   end

   assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rdconv_n && !select_n) |=> !busy);

   assert_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (rdconv_n || select_n)) |=> busy);

   assert_pulse_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (pulses == DATA_W));

   assert_stable_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dclk != $past(dclk)) |-> (sdata == $past(sdata)));

   assert_clock_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dclk);

   assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (lowcnt == CONV_CYCLES));

   assert_ignore_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (lowcnt < CONV_CYCLES - 1)) |=> !busy);
endmodule

bind conv_serial_out conv_serial_out_chk #(
   .DATA_W      (DATA_W),
   .CONV_CYCLES (CONV_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rdconv_n (rdconv_n),
   .select_n (select_n),
   .busy     (busy),
   .dclk     (dclk),
   .sdata    (sdata)
);

// File: tb/conv_serial_out_test.sv
module conv_serial_out_test;
   localparam int DW   = 16;
   localparam int Q    = 2;
   localparam int CONV = 160;
   localparam int SLOT = 4 * Q;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, rdconv_n, select_n, tag_in;
   logic [DW-1:0] result_in;
   logic          busy, dclk, sdata;

   conv_serial_out #(.DATA_W(DW), .QTR(Q), .CONV_CYCLES(CONV)) uut (
      .clk(clk), .rst_n(rst_n), .rdconv_n(rdconv_n), .select_n(select_n),
      .tag_in(tag_in), .result_in(result_in),
      .busy(busy), .dclk(dclk), .sdata(sdata)
   );

   int total = 0;
   int fails = 0;
   bit finished = 0;
   bit cmp_en = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   // Behavioural reference: m_c counts cycles since the start edge, -1 when idle.
   int            m_c;
   logic [DW-1:0] m_prev, m_word;
   logic          m_tag;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_c = -1; m_prev = '0; m_word = '0; m_tag = 1'b0;
      end else begin
         if (m_c == Q) m_tag = tag_in;
         if (m_c == CONV - 1) begin
            m_prev = result_in;
            m_c = -1;
         end else if (m_c >= 0) begin
            m_c++;
         end else if (!rdconv_n && !select_n) begin
            m_c = 0;
            m_word = m_prev;
         end
      end
   end

   function automatic logic exp_busy();
      return !(m_c >= 0);
   endfunction
   function automatic logic exp_dclk();
      if (m_c < 0 || m_c >= DW * SLOT) return 1'b0;
      return ((m_c % SLOT) >= Q) && ((m_c % SLOT) < 3 * Q);
   endfunction
   function automatic logic exp_sdata();
      if (m_c >= 0 && m_c < DW * SLOT) return m_word[DW - 1 - m_c / SLOT];
      return m_tag;
   endfunction

   // Per-cycle comparison and edge-based monitors, sampled at the falling edge.
   logic prev_dclk = 1'b0, prev_busy = 1'b1, prev_sdata = 1'b0;
   int   rises = 0, lows = 0;

   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         chk(busy == exp_busy(), "R7/R1/R8 busy", busy, exp_busy());
         chk(dclk == exp_dclk(), "R2/R5 dclk", dclk, exp_dclk());
         chk(sdata == exp_sdata(), "R3/R6 sdata", sdata, exp_sdata());
         if (dclk != prev_dclk)
            chk(sdata == prev_sdata, "R4 sdata steady at dclk edge", sdata, prev_sdata);
         if (dclk && !prev_dclk) rises++;
         if (!busy) lows++;
         if (busy && !prev_busy) begin
            chk(rises == DW, "R2 pulse count", rises, DW);
            chk(lows == CONV, "R7 busy low length", lows, CONV);
            rises = 0;
            lows = 0;
         end
      end
      prev_dclk = dclk;
      prev_busy = busy;
      prev_sdata = sdata;
   end

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      report();
   end

   task automatic start_req();
      @(negedge clk);
      rdconv_n = 1'b0; select_n = 1'b0;
      @(negedge clk);
      rdconv_n = 1'b1; select_n = 1'b1;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!busy);
   endtask

   initial begin
      rst_n = 1'b0; rdconv_n = 1'b1; select_n = 1'b1;
      tag_in = 1'b0; result_in = '0;
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R9 reset busy", busy, 1);
      chk(dclk == 1'b0, "R9 reset dclk", dclk, 0);
      chk(sdata == 1'b0, "R9 reset sdata", sdata, 0);
      rst_n = 1'b1;
      cmp_en = 1;

      // R1: a single low control must not start a conversion.
      rdconv_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R1 rdconv_n only", busy, 1);
      rdconv_n = 1'b1; select_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R1 select_n only", busy, 1);
      select_n = 1'b1;

      // Conversion 1: sends the reset-state zero word, stores A5C3.
      tag_in = 1'b1; result_in = 16'hA5C3;
      start_req();
      wait_done();
      repeat (6) @(negedge clk);
      chk(sdata == 1'b1, "R6 tag after burst", sdata, 1);
      chk(dclk == 1'b0, "R5 clock idle", dclk, 0);

      // Conversion 2: tag changes after the first pulse; restart request mid-conversion.
      tag_in = 1'b0;
      start_req();
      repeat (Q + 2) @(negedge clk);
      tag_in = 1'b1;
      repeat (20) @(negedge clk);
      start_req();                       // R8: must be ignored
      result_in = 16'h8001;
      wait_done();
      chk(sdata == 1'b0, "R6 captured first-pulse tag", sdata, 0);

      // Conversion 3 back to back: sends 8001, stores 7FFE.
      result_in = 16'h7FFE;
      start_req();
      wait_done();
      // Conversion 4 immediately after busy rises: sends 7FFE.
      tag_in = 1'b0; result_in = 16'h0F0F;
      rdconv_n = 1'b0; select_n = 1'b0;
      @(negedge clk);
      rdconv_n = 1'b1; select_n = 1'b1;
      chk(busy == 1'b0, "R1 start right after busy rise", busy, 0);
      wait_done();
      repeat (4) @(negedge clk);
      report();
   end
endmodule